// File: doc/BRIEF.md
# Dual Down-Counting Timer Unit

This block holds two independent down-counters behind a small synchronous register port. Each counter has its own control word, a live count and a reload value. A counter is started by a control write that sets its enable bit. From then on it decrements once per prescaled tick, where the prescaler divides the clock by 1, 4, 8 or 16. When a counter is at zero and a tick arrives, it raises its terminal-count event. In auto-reload mode it then restarts from its reload value. In one-shot mode it stays at zero and disarms itself.

Terminal-count events of both counters are held in one shared status word, one bit per counter. Each bit drives its own interrupt line and is cleared by writing a one to it. The usual arrangement uses one counter as a periodic tick source and runs the other free from an all-ones reload value. Software then reads the free-running counter and takes elapsed time as the difference of two readings modulo 2^32. Either counter can be locked so that only privileged bus masters can reach its registers.

Top module: `tick_timer_pair`

## Requirements
- R1: After reset every register reads zero and both interrupt lines are low.
- R2: Register word index (byte address bits [4:2]) decodes as 0/1 control of timer 0/1, 2/3 count, 4/5 reload, 6 status, 7 reserved. A read returns data on `bus_rdata` in the cycle after the read is sampled. Control reads as bit 0 terminal-count flag, bit 1 enable, bit 2 auto-reload, bit 3 privileged-only, bits [5:4] prescale. Bit 0 of a control write has no effect.
- R3: Prescale field values 00, 01, 10 and 11 make the count drop by one every 1, 4, 8 and 16 clocks. The first drop comes that many clocks after the edge that samples the enabling control write.
- R4: Every control write with the enable bit set restarts the prescaler from zero, even if the timer is already running.
- R5: With auto-reload set and a reload value of N-1, a timer flags terminal count every N prescaled ticks and resumes from the reload value.
- R6: With auto-reload set and a reload value of all ones, the counter wraps from zero to all ones. The difference of two readings, taken modulo 2^32, equals the clocks between them at prescale 1:1.
- R7: With auto-reload clear, a tick at zero flags terminal count, clears the enable bit and leaves the count at zero.
- R8: Status bit n (address 0x18) latches terminal count of timer n and is mirrored in bit 0 of that timer's control word. `irq[n]` is high exactly while the bit is set.
- R9: Writing 1 to a status bit clears it and writing 0 leaves it. A terminal count in the same cycle as the clear keeps the bit set.
- R10: A count write loads the counter directly and takes precedence over a tick in the same cycle.
- R11: When a timer's privileged-only bit is set, an access with `bus_priv` low to that timer's control, count or reload reads zero and its write is dropped.
- R12: The reserved word reads zero and writes to it change nothing. A disabled timer holds its count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address, word index in bits [4:2] |
| bus_wdata | input | 32 | Write data |
| bus_priv | input | 1 | Access is made in privileged mode |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| irq | output | 2 | Per-timer interrupt, high while its status bit is set |

## Verification
Every bus operation is driven on a falling edge and sampled on the next rising edge. The bench counts rising edges from the edge that sampled a control write. A count drops D edges after enabling and every D edges after that. A terminal count sets status and the interrupt line N·D edges after enabling. Read data is due one edge after the read is sampled. Counts are read only after a disabling write whose edge is known, so the expected value is the start value minus floor(edges/D). For the same-cycle cases, the bench places a status clear or a count write on the exact edge of a terminal count or a tick. This checks the precedence rules, not just the steady behaviour.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

    localparam int unsigned TMR_NUM  = 2;
    localparam int unsigned ADDR_W   = 5;
    localparam int unsigned PRE_W    = 4;
    localparam int unsigned CTRL_W   = 6;

    typedef enum logic [2:0] {
        RI_CTRL0 = 3'd0,
        RI_CTRL1 = 3'd1,
        RI_CNT0  = 3'd2,
        RI_CNT1  = 3'd3,
        RI_RLD0  = 3'd4,
        RI_RLD1  = 3'd5,
        RI_STAT  = 3'd6,
        RI_WDOG  = 3'd7
    } reg_idx_e;

    // Stored control fields; bit 0 of the bus view is the status mirror.
    typedef struct packed {
        logic [1:0] ratio;
        logic       priv;
        logic       autold;
        logic       en;
    } tmr_ctrl_t;

    function automatic logic [PRE_W-1:0] ratio_limit(input logic [1:0] r);
        logic [PRE_W-1:0] lim;
        case (r)
            2'b00:   lim = PRE_W'(0);
            2'b01:   lim = PRE_W'(3);
            2'b10:   lim = PRE_W'(7);
            default: lim = PRE_W'(15);
        endcase
        return lim;
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tick_timer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       restart,
    input  logic [1:0] ratio,
    output logic       tick
);

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_state_t;

    pre_state_t       st_d, st_q;
    logic [PRE_W-1:0] lim;

    always_comb begin
        st_d = st_q;
        lim  = ratio_limit(ratio);
        // >= keeps ticking if the ratio is lowered while running
        tick = run && (st_q.cnt >= lim);
        if (!run || restart || tick) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tick_timer_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_we,
    input  tmr_ctrl_t        ctrl_wr,
    input  logic             cnt_we,
    input  logic             rld_we,
    input  logic [CNT_W-1:0] wdata,
    output tmr_ctrl_t        ctrl_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] rld_o,
    output logic             tc_o
);

    typedef struct packed {
        tmr_ctrl_t        ctrl;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] rld;
    } chan_state_t;

    chan_state_t st_d, st_q;
    logic        tick;

    tmr_prescaler u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (st_q.ctrl.en),
        .restart (ctrl_we && ctrl_wr.en),
        .ratio   (st_q.ctrl.ratio),
        .tick    (tick)
    );

    always_comb begin
        st_d = st_q;
        tc_o = 1'b0;
        if (tick) begin
            if (st_q.cnt == '0) begin
                tc_o = 1'b1;
                if (st_q.ctrl.autold) begin
                    st_d.cnt = st_q.rld;
                end else begin
                    st_d.ctrl.en = 1'b0;
                end
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
        if (ctrl_we) begin
            st_d.ctrl = ctrl_wr;
        end
        if (cnt_we) begin
            st_d.cnt = wdata;
        end
        if (rld_we) begin
            st_d.rld = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_o = st_q.ctrl;
    assign cnt_o  = st_q.cnt;
    assign rld_o  = st_q.rld;

endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
    import tick_timer_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            bus_sel,
    input  logic                            bus_wr,
    input  logic [ADDR_W-1:0]               bus_addr,
    input  logic                            bus_priv,
    input  logic [TMR_NUM-1:0]              clr_bits,
    input  tmr_ctrl_t [TMR_NUM-1:0]         ctrl_i,
    input  logic [TMR_NUM-1:0][CNT_W-1:0]   cnt_i,
    input  logic [TMR_NUM-1:0][CNT_W-1:0]   rld_i,
    input  logic [TMR_NUM-1:0]              tc_i,
    output logic [TMR_NUM-1:0]              ctrl_we,
    output logic [TMR_NUM-1:0]              cnt_we,
    output logic [TMR_NUM-1:0]              rld_we,
    output logic [TMR_NUM-1:0]              stat_o,
    output logic [CNT_W-1:0]                rdata_o
);

    typedef struct packed {
        logic [TMR_NUM-1:0] stat;
        logic [CNT_W-1:0]   rdata;
    } regs_state_t;

    regs_state_t      st_d, st_q;
    logic [2:0]       idx;
    logic             tsel;
    logic             is_tmr;
    logic             acc_ok;
    logic             wr_ok;
    logic             stat_wr;
    logic [CNT_W-1:0] rd_val;
    logic [1:0]       unused_addr_lsb;

    assign unused_addr_lsb = bus_addr[1:0];

    always_comb begin
        idx     = bus_addr[ADDR_W-1:2];
        tsel    = idx[0];
        is_tmr  = (idx[2:1] != 2'b11);
        acc_ok  = bus_priv || !ctrl_i[tsel].priv;
        wr_ok   = bus_sel && bus_wr && is_tmr && acc_ok;
        stat_wr = bus_sel && bus_wr && (idx == RI_STAT);
        for (int n = 0; n < int'(TMR_NUM); n++) begin
            ctrl_we[n] = wr_ok && (idx[2:1] == 2'b00) && (tsel == n[0]);
            cnt_we[n]  = wr_ok && (idx[2:1] == 2'b01) && (tsel == n[0]);
            rld_we[n]  = wr_ok && (idx[2:1] == 2'b10) && (tsel == n[0]);
        end
    end

    always_comb begin
        rd_val = '0;
        case (idx[2:1])
            2'b00:   rd_val[CTRL_W-1:0] = {ctrl_i[tsel], st_q.stat[tsel]};
            2'b01:   rd_val = cnt_i[tsel];
            2'b10:   rd_val = rld_i[tsel];
            default: begin
                if (idx == RI_STAT) begin
                    rd_val[TMR_NUM-1:0] = st_q.stat;
                end
            end
        endcase
        if (is_tmr && !acc_ok) begin
            rd_val = '0;
        end
    end

    always_comb begin
        st_d = st_q;
        if (stat_wr) begin
            st_d.stat = st_q.stat & ~clr_bits;
        end
        st_d.stat = st_d.stat | tc_i;
        if (bus_sel && !bus_wr) begin
            st_d.rdata = rd_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_o  = st_q.stat;
    assign rdata_o = st_q.rdata;

endmodule

// File: rtl/tick_timer_pair.sv
module tick_timer_pair
    import tick_timer_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    input  logic              bus_priv,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic [TMR_NUM-1:0] irq
);

    tmr_ctrl_t [TMR_NUM-1:0]         ctrl_q;
    logic [TMR_NUM-1:0][CNT_W-1:0]   cnt_q;
    logic [TMR_NUM-1:0][CNT_W-1:0]   rld_q;
    logic [TMR_NUM-1:0]              tc_pulse;
    logic [TMR_NUM-1:0]              ctrl_we;
    logic [TMR_NUM-1:0]              cnt_we;
    logic [TMR_NUM-1:0]              rld_we;
    logic [TMR_NUM-1:0]              en_vec;
    logic [TMR_NUM-1:0]              priv_vec;
    tmr_ctrl_t                       wr_ctrl;

    assign wr_ctrl = tmr_ctrl_t'(bus_wdata[CTRL_W-1:1]);

    tmr_regs #(.CNT_W(CNT_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_priv (bus_priv),
        .clr_bits (bus_wdata[TMR_NUM-1:0]),
        .ctrl_i   (ctrl_q),
        .cnt_i    (cnt_q),
        .rld_i    (rld_q),
        .tc_i     (tc_pulse),
        .ctrl_we  (ctrl_we),
        .cnt_we   (cnt_we),
        .rld_we   (rld_we),
        .stat_o   (irq),
        .rdata_o  (bus_rdata)
    );

    for (genvar g = 0; g < int'(TMR_NUM); g++) begin : g_tmr
        tmr_channel #(.CNT_W(CNT_W)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .ctrl_we (ctrl_we[g]),
            .ctrl_wr (wr_ctrl),
            .cnt_we  (cnt_we[g]),
            .rld_we  (rld_we[g]),
            .wdata   (bus_wdata),
            .ctrl_o  (ctrl_q[g]),
            .cnt_o   (cnt_q[g]),
            .rld_o   (rld_q[g]),
            .tc_o    (tc_pulse[g])
        );
        assign en_vec[g]   = ctrl_q[g].en;
        assign priv_vec[g] = ctrl_q[g].priv;
    end

endmodule

// File: rtl/tick_timer_pair_chk.sv
module tick_timer_pair_chk #(
    parameter int unsigned CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic [4:0]       bus_addr,
    input logic             bus_priv,
    input logic [CNT_W-1:0] bus_rdata,
    input logic [1:0]       irq,
    input logic [1:0]       en_vec,
    input logic [1:0]       priv_vec,
    input logic [CNT_W-1:0] cnt0,
    input logic [CNT_W-1:0] rld0
);

    logic cnt0_wr;
    logic ctrl0_wr;
    logic rd_any;

    assign cnt0_wr  = bus_sel && bus_wr && (bus_addr[4:2] == 3'd2);
    assign ctrl0_wr = bus_sel && bus_wr && (bus_addr[4:2] == 3'd0);
    assign rd_any   = bus_sel && !bus_wr;

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_vec[0] && !cnt0_wr) |=> $stable(cnt0)); // R12

    AST_STEP_OR_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (en_vec[0] && !cnt0_wr) |=> ((cnt0 == $past(cnt0)) || (cnt0 == $past(cnt0) - 1'b1) || (cnt0 == $past(rld0)))); // R3

    AST_IRQ_AFTER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq[0]) |-> ($past(cnt0) == '0)); // R8

    AST_ONESHOT_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(en_vec[0]) && !$past(ctrl0_wr)) |-> irq[0]); // R7

    AST_PRIV_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_any && !bus_priv && (bus_addr[4:3] != 2'b11) && (bus_addr[2] ? priv_vec[1] : priv_vec[0])) |=> (bus_rdata == '0)); // R11

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_any && (bus_addr[4:2] == 3'd7)) |=> (bus_rdata == '0)); // R12

endmodule

bind tick_timer_pair tick_timer_pair_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_priv  (bus_priv),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .en_vec    (en_vec),
    .priv_vec  (priv_vec),
    .cnt0      (cnt_q[0]),
    .rld0      (rld_q[0])
);

// File: tb/tick_timer_pair_tb_top.sv
module tick_timer_pair_tb_top;

    localparam logic [4:0] A_CTRL0 = 5'h00;
    localparam logic [4:0] A_CTRL1 = 5'h04;
    localparam logic [4:0] A_CNT0  = 5'h08;
    localparam logic [4:0] A_CNT1  = 5'h0C;
    localparam logic [4:0] A_RLD0  = 5'h10;
    localparam logic [4:0] A_RLD1  = 5'h14;
    localparam logic [4:0] A_STAT  = 5'h18;
    localparam logic [4:0] A_WDOG  = 5'h1C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_priv = 1'b1;
    logic [31:0] bus_rdata;
    logic [1:0]  irq;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 1'b0;

    always #10 clk = ~clk;

    tick_timer_pair dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_priv  (bus_priv),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // Called on a falling edge; the access is sampled on the next rising edge.
    task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic p = 1'b1);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_priv = p;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_priv = 1'b1;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d, input logic p = 1'b1);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_priv = p;
        @(negedge clk);
        bus_sel = 1'b0; bus_priv = 1'b1;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd0, 32'd1);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, a, b;
        int d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq", {30'd0, irq}, 32'd0);
        for (int i = 0; i < 8; i++) begin
            rd(5'(i * 4), v);
            chk("R1 reg", v, 32'd0);
        end

        // R2 map and field layout
        wr(A_RLD0, 32'h1234_5678);
        rd(A_RLD0, v);  chk("R2 reload0", v, 32'h1234_5678);
        wr(A_CNT1, 32'hCAFE_0001);
        rd(A_CNT1, v);  chk("R2 count1", v, 32'hCAFE_0001);
        rd(A_CNT0, v);  chk("R2 count0 untouched", v, 32'd0);
        wr(A_CTRL0, 32'h34);
        rd(A_CTRL0, v); chk("R2 ctrl0 fields", v, 32'h34);
        wr(A_CTRL1, 32'h01);
        rd(A_CTRL1, v); chk("R2 ctrl bit0 write ignored", v, 32'h00);
        wr(A_CTRL0, 32'h0);

        // R3 prescale sweep: elapsed edges k+1 between enable and disable
        for (int r = 0; r < 4; r++) begin
            d = (r == 0) ? 1 : (r == 1) ? 4 : (r == 2) ? 8 : 16;
            for (int k = 0; k < 20; k++) begin
                wr(A_CNT0, 32'd100);
                wr(A_CTRL0, 32'h02 | (r << 4));
                idle(k);
                wr(A_CTRL0, 32'h0);
                rd(A_CNT0, v);
                chk("R3 prescaled count", v, 32'd100 - 32'((k + 1) / d));
            end
            idle(5);
            rd(A_CNT0, b);
            chk("R12 disabled holds", b, v);
        end

        // R4 restart on re-enable (divide by 4)
        wr(A_CNT0, 32'd100);
        wr(A_CTRL0, 32'h12);
        idle(2);
        wr(A_CTRL0, 32'h12);
        idle(2);
        wr(A_CTRL0, 32'h0);
        rd(A_CNT0, v);
        chk("R4 prescaler restart", v, 32'd100);

        // R5 periodic reload, R8 irq, R9 clear
        for (int r = 0; r < 2; r++) begin
            d = (r == 0) ? 1 : 4;
            for (int n = 3; n <= 6; n++) begin
                wr(A_RLD0, 32'(n - 1));
                wr(A_CNT0, 32'(n - 1));
                wr(A_CTRL0, 32'h06 | (r << 4));
                idle(n * d - 1);
                chk("R5 no tc before period", {31'd0, irq[0]}, 32'd0);
                idle(1);
                chk("R8 irq on tc", {31'd0, irq[0]}, 32'd1);
                wr(A_STAT, 32'h1);
                chk("R9 w1c clears", {31'd0, irq[0]}, 32'd0);
                idle(n * d - 2);
                chk("R5 second period early", {31'd0, irq[0]}, 32'd0);
                idle(1);
                chk("R5 second period tc", {31'd0, irq[0]}, 32'd1);
                wr(A_CTRL0, 32'h0);
                rd(A_CNT0, v);
                chk("R5 reloaded count", v, (d == 1) ? 32'(n - 2) : 32'(n - 1));
                wr(A_STAT, 32'h1);
            end
        end

        // R9 set wins over clear in the same cycle
        wr(A_RLD0, 32'd2);
        wr(A_CNT0, 32'd2);
        wr(A_CTRL0, 32'h06);
        idle(5);
        wr(A_STAT, 32'h1);
        chk("R9 set beats clear", {31'd0, irq[0]}, 32'd1);
        wr(A_STAT, 32'h0);
        chk("R9 write zero keeps", {31'd0, irq[0]}, 32'd1);
        wr(A_STAT, 32'h1);
        chk("R9 clear later", {31'd0, irq[0]}, 32'd0);
        wr(A_CTRL0, 32'h0);
        wr(A_STAT, 32'h1);

        // R6 free-running timer 1 with wrap
        wr(A_CNT1, 32'd0);
        wr(A_RLD1, 32'hFFFF_FFFF);
        wr(A_CTRL1, 32'h06);
        idle(3);
        rd(A_CNT1, a);
        chk("R6 wrapped value", a, 32'hFFFF_FFFD);
        idle(6);
        rd(A_CNT1, b);
        chk("R6 elapsed mod 2^32", a - b, 32'd7);
        rd(A_CTRL1, v); chk("R8 ctrl1 mirror", v, 32'h07);
        rd(A_STAT, v);  chk("R8 status bit1", v, 32'h2);
        chk("R8 irq1", {30'd0, irq}, 32'h2);
        wr(A_CTRL1, 32'h0);
        wr(A_STAT, 32'h2);
        chk("R9 clear bit1", {30'd0, irq}, 32'h0);

        // R7 one-shot
        wr(A_CNT0, 32'd5);
        wr(A_CTRL0, 32'h02);
        idle(5);
        chk("R7 no tc yet", {31'd0, irq[0]}, 32'd0);
        idle(1);
        chk("R7 tc", {31'd0, irq[0]}, 32'd1);
        rd(A_CTRL0, v); chk("R7 disarmed", v, 32'h01);
        idle(3);
        rd(A_CNT0, v);  chk("R7 stays zero", v, 32'd0);
        wr(A_STAT, 32'h1);

        // R10 count write beats tick
        wr(A_CNT0, 32'd50);
        wr(A_CTRL0, 32'h02);
        wr(A_CNT0, 32'd7);
        wr(A_CTRL0, 32'h0);
        rd(A_CNT0, v);
        chk("R10 load over tick", v, 32'd6);

        // R11 privilege
        wr(A_CNT1, 32'hAA);
        wr(A_CTRL1, 32'h08);
        rd(A_CTRL1, v, 1'b0); chk("R11 ctrl hidden", v, 32'd0);
        rd(A_CNT1, v, 1'b0);  chk("R11 count hidden", v, 32'd0);
        rd(A_RLD1, v, 1'b0);  chk("R11 reload hidden", v, 32'd0);
        wr(A_CNT1, 32'h55, 1'b0);
        wr(A_CTRL1, 32'h00, 1'b0);
        rd(A_CNT1, v);  chk("R11 write dropped", v, 32'hAA);
        rd(A_CTRL1, v); chk("R11 priv kept", v, 32'h08);
        wr(A_CNT0, 32'h33, 1'b0);
        rd(A_CNT0, v, 1'b0); chk("R11 open timer", v, 32'h33);
        wr(A_CTRL1, 32'h0);

        // R12 reserved word
        wr(A_WDOG, 32'hFFFF_FFFF);
        rd(A_WDOG, v); chk("R12 reserved reads zero", v, 32'd0);
        rd(A_STAT, v); chk("R12 status untouched", v, 32'd0);
        rd(A_CTRL0, v); chk("R12 ctrl0 untouched", v, 32'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule